// File: doc/BRIEF.md
# Timer interrupt flag register

This block keeps the three event flags of an 8-bit timer (compare match A, compare match B and counter overflow). It also holds one interrupt enable per flag and drives one interrupt request line per flag. The timer core sends a one-cycle pulse for each event, and that pulse sets the matching flag. A flag goes back to zero in one of two ways. The interrupt controller can return a one-cycle acknowledge when it enters the flag's vector. Software can also write a one to the flag's bit through the register port.

Software reads the flags and the enables through two 8-bit views. Each source uses the same bit position in both views. Every other bit reads as zero. A request line is high only while the global interrupt enable, the source's own enable and its flag are all set. The counter, the compare logic and the vector priority logic sit outside this block.

Top module: `timer_irq_flags`

## Requirements
- R1: A synchronous active-high `rst` clears all flags and all enables. While and after reset, `flag_rd`, `mask_rd` and `irq` are all zero.
- R2: In both `flag_rd` and `mask_rd`, compare A is at bit 4, compare B at bit 3 and overflow at bit 1. Bits 7, 6, 5, 2 and 0 always read zero.
- R3: The vectors `evt`, `ack` and `irq` use one bit per source: bit 2 is compare A, bit 1 is compare B and bit 0 is overflow. An `evt` bit high at a clock edge sets the matching flag, and the flag is visible after that edge.
- R4: An `ack` bit high at a clock edge clears the matching flag.
- R5: When `wr_flag` is high with a one at a flag's bit position of `wr_data`, that flag is cleared at the clock edge.
- R6: A zero at a flag's bit position during a flag write leaves that flag unchanged. Data in the unused bit positions has no effect on any flag or enable.
- R7: If a set and a clear (acknowledge or write-one) reach the same flag at the same edge, the flag ends up set.
- R8: When `wr_mask` is high, the three enables load from bits 4, 3 and 1 of `wr_data` at the clock edge. Otherwise they hold.
- R9: Each `irq` bit equals `gie` AND that source's enable AND its flag, combinationally, with no added delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt | input | 3 | Event pulses {cmp A, cmp B, overflow} |
| ack | input | 3 | Vector acknowledge pulses {cmp A, cmp B, overflow} |
| wr_flag | input | 1 | Write strobe for the flag register (write-one-to-clear) |
| wr_mask | input | 1 | Write strobe for the enable register |
| wr_data | input | 8 | Write data |
| gie | input | 1 | Global interrupt enable |
| flag_rd | output | 8 | Flag register read view |
| mask_rd | output | 8 | Enable register read view |
| irq | output | 3 | Interrupt requests {cmp A, cmp B, overflow} |

## Verification
The bench runs every combination of prior flag state, event, acknowledge and write-one pattern, each with and without a flag write. The write data always carries ones in the unused bit positions. This covers the collision case where a set and a clear meet at the same edge: a design that let the clear win would drop the event. A design that cleared on a written zero, or decoded the wrong bit, would show a flag differing from the model. A full sweep of the global enable, the enables and the flags catches any request line that ignores one of its three terms. A second reset in the middle of the run shows whether any state survives reset.

// File: rtl/timer_irq_flags.sv
module timer_irq_flags #(
  parameter int unsigned DW       = 8,
  parameter int unsigned POS_CMPA = 4,
  parameter int unsigned POS_CMPB = 3,
  parameter int unsigned POS_OVF  = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    evt,
  input  logic [2:0]    ack,
  input  logic          wr_flag,
  input  logic          wr_mask,
  input  logic [DW-1:0] wr_data,
  input  logic          gie,
  output logic [DW-1:0] flag_rd,
  output logic [DW-1:0] mask_rd,
  output logic [2:0]    irq
);
  localparam int unsigned NSRC = 3;
  localparam int unsigned POS [NSRC] = '{POS_OVF, POS_CMPB, POS_CMPA};

  logic [NSRC-1:0] flag_q, mask_q, wsel, clr;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign wsel[i] = wr_data[POS[i]];
  end

  assign clr = ack | ({NSRC{wr_flag}} & wsel);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      mask_q <= '0;
    end else begin
      flag_q <= (flag_q & ~clr) | evt;
      if (wr_mask) mask_q <= wsel;
    end
  end

  always_comb begin
    flag_rd = '0;
    mask_rd = '0;
    for (int i = 0; i < NSRC; i++) begin
      flag_rd[POS[i]] = flag_q[i];
      mask_rd[POS[i]] = mask_q[i];
    end
  end

  assign irq = {NSRC{gie}} & mask_q & flag_q;

  logic unused_wdata;
  assign unused_wdata = ^wr_data;
endmodule

// File: rtl/timer_irq_flags_chk.sv
module timer_irq_flags_chk #(
  parameter int unsigned DW       = 8,
  parameter int unsigned POS_CMPA = 4,
  parameter int unsigned POS_CMPB = 3,
  parameter int unsigned POS_OVF  = 1
) (
  input logic          clk,
  input logic          rst,
  input logic [2:0]    evt,
  input logic [2:0]    ack,
  input logic          wr_flag,
  input logic          wr_mask,
  input logic [DW-1:0] wr_data,
  input logic          gie,
  input logic [DW-1:0] flag_rd,
  input logic [DW-1:0] mask_rd,
  input logic [2:0]    irq
);
  localparam int unsigned POS [3] = '{POS_OVF, POS_CMPB, POS_CMPA};
  localparam logic [DW-1:0] USED = (DW'(1) << POS_CMPA) | (DW'(1) << POS_CMPB) | (DW'(1) << POS_OVF);

  assert_reset_clears_R1: assert property (@(posedge clk) rst |=> (flag_rd == '0 && mask_rd == '0));
  assert_unused_zero_R2: assert property (@(posedge clk) disable iff (rst)
    ((flag_rd & ~USED) == '0 && (mask_rd & ~USED) == '0));

  for (genvar i = 0; i < 3; i++) begin : g_chk
    assert_event_sets_R3: assert property (@(posedge clk) disable iff (rst)
      evt[i] |=> flag_rd[POS[i]]);
    assert_ack_clears_R4: assert property (@(posedge clk) disable iff (rst)
      (ack[i] && !evt[i]) |=> !flag_rd[POS[i]]);
    assert_w1c_clears_R5: assert property (@(posedge clk) disable iff (rst)
      (wr_flag && wr_data[POS[i]] && !evt[i]) |=> !flag_rd[POS[i]]);
    assert_w0_holds_R6: assert property (@(posedge clk) disable iff (rst)
      (wr_flag && !wr_data[POS[i]] && !evt[i] && !ack[i]) |=> (flag_rd[POS[i]] == $past(flag_rd[POS[i]])));
    assert_mask_load_R8: assert property (@(posedge clk) disable iff (rst)
      wr_mask |=> (mask_rd[POS[i]] == $past(wr_data[POS[i]])));
    assert_irq_terms_R9: assert property (@(posedge clk) disable iff (rst)
      irq[i] |-> (gie && mask_rd[POS[i]] && flag_rd[POS[i]]));
  end
endmodule

bind timer_irq_flags timer_irq_flags_chk #(
  .DW(DW), .POS_CMPA(POS_CMPA), .POS_CMPB(POS_CMPB), .POS_OVF(POS_OVF)
) u_chk (
  .clk(clk), .rst(rst), .evt(evt), .ack(ack), .wr_flag(wr_flag), .wr_mask(wr_mask),
  .wr_data(wr_data), .gie(gie), .flag_rd(flag_rd), .mask_rd(mask_rd), .irq(irq)
);

// File: tb/timer_irq_flags_bench.sv
module timer_irq_flags_bench;
  logic       clk = 0;
  logic       rst = 1;
  logic [2:0] evt = 0, ack = 0;
  logic       wr_flag = 0, wr_mask = 0, gie = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] flag_rd, mask_rd;
  logic [2:0] irq;

  int n_tests = 0, n_fail = 0;
  logic [2:0] m_flag = 0, m_mask = 0;
  bit done = 0;

  timer_irq_flags u_timer_irq_flags (
    .clk(clk), .rst(rst), .evt(evt), .ack(ack), .wr_flag(wr_flag), .wr_mask(wr_mask),
    .wr_data(wr_data), .gie(gie), .flag_rd(flag_rd), .mask_rd(mask_rd), .irq(irq)
  );

  always #5 clk = ~clk;

  function automatic logic [7:0] spread(input logic [2:0] v);
    return {3'b000, v[2], v[1], 1'b0, v[0], 1'b0};
  endfunction

  function automatic logic [2:0] pick(input logic [7:0] d);
    return {d[4], d[3], d[1]};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] e, input logic [2:0] a, input logic wf,
                      input logic wm, input logic [7:0] d);
    evt = e; ack = a; wr_flag = wf; wr_mask = wm; wr_data = d;
    m_flag = (m_flag & ~(a | (wf ? pick(d) : 3'b000))) | e;
    if (wm) m_mask = pick(d);
    @(negedge clk);
    evt = 0; ack = 0; wr_flag = 0; wr_mask = 0; wr_data = 0;
  endtask

  task automatic check_all(input string req);
    check({req, " flags"}, flag_rd, spread(m_flag));
    check({req, " enables"}, mask_rd, spread(m_mask));
    check({req, " irq"}, {5'b0, irq}, {5'b0, {3{gie}} & m_mask & m_flag});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_all("R1 reset");
    rst = 0;
    @(negedge clk);
    check_all("R1 after reset");

    // R3 R4 R5 R6 R7: every prior state x event x ack x write pattern, unused bits set in data
    for (int wf = 0; wf < 2; wf++)
      for (int pre = 0; pre < 8; pre++)
        for (int e = 0; e < 8; e++)
          for (int a = 0; a < 8; a++)
            for (int w = 0; w < 8; w++) begin
              step(3'b000, 3'b111, 1'b0, 1'b0, 8'h00);
              step(3'(pre), 3'b000, 1'b0, 1'b0, 8'h00);
              step(3'(e), 3'(a), 1'(wf), 1'b0, spread(3'(w)) | 8'hE5);
              check("R3 R4 R5 R6 R7 R2 flag update", flag_rd, spread(m_flag));
            end

    // R8 R9 R2: enables load, unused data bits ignored, irq over all terms
    for (int g = 0; g < 2; g++)
      for (int m = 0; m < 8; m++)
        for (int f = 0; f < 8; f++) begin
          gie = 1'(g);
          step(3'b000, 3'b111, 1'b0, 1'b1, spread(3'(m)) | 8'hE5);
          step(3'(f), 3'b000, 1'b0, 1'b0, 8'h00);
          check_all("R8 R9 R2 enable and request");
        end

    // R8: enables hold when not written
    step(3'b000, 3'b000, 1'b1, 1'b0, 8'hFF);
    check_all("R8 hold");

    // R1: reset in the middle of activity
    gie = 1;
    step(3'b111, 3'b000, 1'b0, 1'b1, 8'hFF);
    check_all("R9 all set");
    rst = 1;
    m_flag = 0; m_mask = 0;
    @(negedge clk);
    check_all("R1 mid-run reset");
    rst = 0;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(negedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule